// File: doc/BRIEF.md
# Serial DAC Input Register

This block is the digital front end of an 8-bit voltage-output DAC. A host writes to it over a three-wire serial link: an active-low frame select, a serial clock and a data line. The block brings all three into the system clock domain, finds the falling edges of the serial clock, and shifts in a 16-bit frame, most significant bit first. Nothing is committed until the sixteenth falling edge arrives while the frame select is still low. At that point the DAC code and a two-bit power mode are loaded together.

A frame that ends early, with the select rising before the sixteenth edge, is discarded. It leaves the stored code and mode as they were and clears the partial frame. The mode field picks one of four output configurations: amplifier driving, pulled to ground through 1k, pulled to ground through 100k, or high impedance. Any power-down mode holds the stored code. When the block returns to normal operation, the output-valid flag is held low for a programmable number of system clocks to cover the amplifier wake-up time.

Top module: `sdac_input_reg`

## Requirements
- R1: After reset the code output is 0x00, the mode is 00, the power-down flag is 0, the output select is 0 (amplifier) and output-valid is 1.
- R2: A frame of 16 falling serial-clock edges with the select held low loads frame bits 11..4 (first bit received is bit 15) into the code output, provided the frame's mode field is 00.
- R3: Frame bits 13..12 load the mode output. The output select equals the mode: 0 amplifier, 1 1k to ground, 2 100k to ground, 3 high impedance. The power-down flag is 1 exactly when the mode is nonzero.
- R4: If the select rises after 1 to 15 falling edges, code and mode keep their previous values, and the next complete frame decodes correctly.
- R5: A frame whose mode field is nonzero changes the mode only. The code output keeps its last value.
- R6: Frame bits 15, 14 and 3..0 have no effect on code or mode.
- R7: Falling edges after the sixteenth, within the same low period of the select, change nothing.
- R8: Output-valid is 0 while in power-down. After a frame returns the mode to 00, output-valid rises exactly WAKE_CYCLES system clocks after the power-down flag falls.
- R9: A mode-00 frame received while already in mode 00 never drops output-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| sync_ni | input | 1 | Serial frame select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, data taken on its falling edge, asynchronous |
| din_i | input | 1 | Serial data, MSB first, asynchronous |
| code_o | output | 8 | Stored DAC code |
| mode_o | output | 2 | Stored power mode |
| pd_o | output | 1 | High in any power-down mode |
| out_sel_o | output | 2 | Output stage select: 0 amp, 1 1k, 2 100k, 3 high-Z |
| out_valid_o | output | 1 | Output settled (low in power-down and during wake-up) |

## Verification
The bench keeps the default frame layout and two synchroniser stages and lowers WAKE_CYCLES to 12. With that value the wake-up window can be counted cycle by cycle, which pins down the exact count and rules out an off-by-one. At a few hundred system clocks per frame, the bench can afford every one of the 256 codes, every abort point from 1 to 15 edges, and all four modes in several orders. Each case uses filler bits that differ from the code, so any leakage from the ignored positions shows.

// File: rtl/sdac_pkg.sv
// Package: shared constants and the output-stage encoding for the serial
// DAC input register. Assumes a two-bit mode field.
package sdac_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [1:0] {
        SEL_AMP   = 2'd0,
        SEL_R1K   = 2'd1,
        SEL_R100K = 2'd2,
        SEL_HIZ   = 2'd3
    } out_sel_e;

    // Map a stored mode field onto the output-stage selection.
    function automatic out_sel_e mode_to_sel(input logic [MODE_W-1:0] m);
        case (m)
            2'd1:    return SEL_R1K;
            2'd2:    return SEL_R100K;
            2'd3:    return SEL_HIZ;
            default: return SEL_AMP;
        endcase
    endfunction

endpackage

// File: rtl/sdac_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is an independent level; STAGES >= 2. Reset loads the
// idle level of each line so no spurious edge appears after reset.
module sdac_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage: capture the raw asynchronous inputs.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) stage_q[0] <= RST_VAL;
        else         stage_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Later stages: let metastability settle.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) stage_q[s] <= RST_VAL;
            else         stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sdac_frame_rx.sv
// Module: frame receiver. Detects falling serial-clock edges in the system
// clock domain, counts bits while select is low and captures only the code
// and mode fields. Raises a one-cycle commit with the decoded fields on the
// final bit. Assumes the inputs are already synchronised and that both
// fields lie inside the frame.
module sdac_frame_rx #(
    parameter int FRAME_BITS = 16,
    parameter int CODE_W     = 8,
    parameter int CODE_LSB   = 4,
    parameter int MODE_LSB   = 12,
    parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       sync_lvl_i,
    input  logic                       sclk_lvl_i,
    input  logic                       din_lvl_i,
    output logic                       commit_o,
    output logic [CODE_W-1:0]          code_o,
    output logic [sdac_pkg::MODE_W-1:0] mode_o,
    output logic [CNT_W-1:0]           bit_cnt_o
);
    import sdac_pkg::*;

    logic                sclk_prev_q;
    logic [CNT_W-1:0]    bit_cnt_q;
    logic [CODE_W-1:0]   code_sh_q;
    logic [MODE_W-1:0]   mode_sh_q;
    logic                sclk_fall;
    logic                accept;
    logic                last_bit;
    logic                in_code;
    logic                in_mode;
    int                  bit_idx;
    logic [CODE_W-1:0]   code_nx;
    logic [MODE_W-1:0]   mode_nx;

    // Remember the previous serial-clock level for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) sclk_prev_q <= 1'b1;
        else         sclk_prev_q <= sclk_lvl_i;
    end

    // Decide whether this cycle takes a bit and where that bit belongs.
    always_comb begin
        sclk_fall = sclk_prev_q & ~sclk_lvl_i;
        accept    = sclk_fall & ~sync_lvl_i & (bit_cnt_q < CNT_W'(FRAME_BITS));
        last_bit  = (bit_cnt_q == CNT_W'(FRAME_BITS - 1));
        bit_idx   = FRAME_BITS - 1 - int'(bit_cnt_q);
        in_code   = (bit_idx >= CODE_LSB) && (bit_idx < CODE_LSB + CODE_W);
        in_mode   = (bit_idx >= MODE_LSB) && (bit_idx < MODE_LSB + MODE_W);
        code_nx   = in_code ? {code_sh_q[CODE_W-2:0], din_lvl_i} : code_sh_q;
        mode_nx   = in_mode ? {mode_sh_q[MODE_W-2:0], din_lvl_i} : mode_sh_q;
    end

    // Bit counter and field shifters; cleared whenever select is high.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bit_cnt_q <= '0;
            code_sh_q <= '0;
            mode_sh_q <= '0;
        end else if (sync_lvl_i) begin
            bit_cnt_q <= '0;
            code_sh_q <= '0;
            mode_sh_q <= '0;
        end else if (accept) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            code_sh_q <= code_nx;
            mode_sh_q <= mode_nx;
        end
    end

    // Commit pulse and captured fields on the last bit of a frame.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            commit_o <= 1'b0;
            code_o   <= '0;
            mode_o   <= '0;
        end else begin
            commit_o <= accept & last_bit;
            if (accept && last_bit) begin
                code_o <= code_nx;
                mode_o <= mode_nx;
            end
        end
    end

    assign bit_cnt_o = bit_cnt_q;

endmodule

// File: rtl/sdac_power_ctl.sv
// Module: holds the DAC code and mode, and times the wake-up window.
// A frame with a nonzero mode updates the mode only. A mode-00 frame updates
// both. Leaving power-down holds output-valid low for WAKE_CYCLES clocks.
// Assumes WAKE_CYCLES >= 1.
module sdac_power_ctl #(
    parameter int CODE_W      = 8,
    parameter int WAKE_CYCLES = 500
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        commit_i,
    input  logic [CODE_W-1:0]           new_code_i,
    input  logic [sdac_pkg::MODE_W-1:0] new_mode_i,
    output logic [CODE_W-1:0]           code_o,
    output logic [sdac_pkg::MODE_W-1:0] mode_o,
    output logic                        valid_o
);
    import sdac_pkg::*;

    localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);

    logic [CODE_W-1:0] code_q;
    logic [MODE_W-1:0] mode_q;
    logic [WAKE_W-1:0] wake_q;
    logic              valid_q;
    logic              to_pd;
    logic              to_normal;

    // Classify the committed frame against the present mode.
    always_comb begin
        to_pd     = commit_i && (new_mode_i != '0);
        to_normal = commit_i && (new_mode_i == '0) && (mode_q != '0);
    end

    // Stored code and mode; the code is frozen by power-down frames.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            code_q <= '0;
            mode_q <= '0;
        end else if (commit_i) begin
            mode_q <= new_mode_i;
            if (new_mode_i == '0) code_q <= new_code_i;
        end
    end

    // Wake-up counter and output-valid flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wake_q  <= '0;
            valid_q <= 1'b1;
        end else if (to_pd) begin
            wake_q  <= '0;
            valid_q <= 1'b0;
        end else if (to_normal) begin
            wake_q  <= WAKE_W'(WAKE_CYCLES);
            valid_q <= 1'b0;
        end else if (wake_q != '0) begin
            wake_q <= wake_q - 1'b1;
            if (wake_q == WAKE_W'(1)) valid_q <= 1'b1;
        end
    end

    assign code_o  = code_q;
    assign mode_o  = mode_q;
    assign valid_o = valid_q;

endmodule

// File: rtl/sdac_input_reg.sv
// Module: top of the serial DAC input register. Synchronises the three
// serial lines, receives 16-bit frames and drives code, mode, power-down
// flag, output-stage select and output-valid. Assumes the serial clock
// phases last at least SYNC_STAGES+1 system clocks.
module sdac_input_reg #(
    parameter int FRAME_BITS  = 16,
    parameter int CODE_W      = 8,
    parameter int CODE_LSB    = 4,
    parameter int MODE_LSB    = 12,
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYCLES = 500
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sync_ni,
    input  logic              sclk_i,
    input  logic              din_i,
    output logic [CODE_W-1:0] code_o,
    output logic [1:0]        mode_o,
    output logic              pd_o,
    output logic [1:0]        out_sel_o,
    output logic              out_valid_o
);
    import sdac_pkg::*;

    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    logic [2:0]        pins_sync;
    logic              sync_lvl_w;
    logic              sclk_lvl_w;
    logic              din_lvl_w;
    logic              commit_w;
    logic [CODE_W-1:0] commit_code_w;
    logic [MODE_W-1:0] commit_mode_w;
    logic [CNT_W-1:0]  bit_cnt_w;

    sdac_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b011)
    ) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({din_i, sclk_i, sync_ni}),
        .q_o    (pins_sync)
    );

    assign sync_lvl_w = pins_sync[0];
    assign sclk_lvl_w = pins_sync[1];
    assign din_lvl_w  = pins_sync[2];

    sdac_frame_rx #(
        .FRAME_BITS (FRAME_BITS),
        .CODE_W     (CODE_W),
        .CODE_LSB   (CODE_LSB),
        .MODE_LSB   (MODE_LSB),
        .CNT_W      (CNT_W)
    ) rx_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sync_lvl_i (sync_lvl_w),
        .sclk_lvl_i (sclk_lvl_w),
        .din_lvl_i  (din_lvl_w),
        .commit_o   (commit_w),
        .code_o     (commit_code_w),
        .mode_o     (commit_mode_w),
        .bit_cnt_o  (bit_cnt_w)
    );

    sdac_power_ctl #(
        .CODE_W      (CODE_W),
        .WAKE_CYCLES (WAKE_CYCLES)
    ) pwr_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .commit_i   (commit_w),
        .new_code_i (commit_code_w),
        .new_mode_i (commit_mode_w),
        .code_o     (code_o),
        .mode_o     (mode_o),
        .valid_o    (out_valid_o)
    );

    // Power-down flag and output-stage select follow the stored mode.
    always_comb begin
        pd_o      = (mode_o != 2'd0);
        out_sel_o = mode_to_sel(mode_o);
    end

endmodule

// File: rtl/sdac_input_reg_chk.sv
// Module: assertion checker for sdac_input_reg, attached by bind.
// Observes the commit strobe, the bit counter and the top-level outputs.
module sdac_input_reg_chk #(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 5,
    parameter int FRAME_BITS = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              commit_i,
    input logic [1:0]        commit_mode_i,
    input logic              sync_lvl_i,
    input logic [CNT_W-1:0]  bit_cnt_i,
    input logic [CODE_W-1:0] code_i,
    input logic [1:0]        mode_i,
    input logic              pd_i,
    input logic              valid_i
);

    AST_CODE_HOLDS_WITHOUT_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni) !commit_i |=> $stable(code_i)); // R4
    AST_MODE_HOLDS_WITHOUT_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni) !commit_i |=> $stable(mode_i)); // R4
    AST_COMMIT_NEEDS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni) commit_i |-> !$past(sync_lvl_i)); // R2
    AST_PD_FRAME_KEEPS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni) (commit_i && commit_mode_i != 2'd0) |=> $stable(code_i)); // R5
    AST_NO_VALID_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_ni) pd_i |-> !valid_i); // R8
    AST_VALID_RISES_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(valid_i) |-> !pd_i); // R8
    AST_BITCNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) bit_cnt_i <= CNT_W'(FRAME_BITS)); // R7
    AST_ABORT_CLEARS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni) sync_lvl_i |=> (bit_cnt_i == '0)); // R4

endmodule

bind sdac_input_reg sdac_input_reg_chk #(
    .CODE_W     (CODE_W),
    .CNT_W      (CNT_W),
    .FRAME_BITS (FRAME_BITS)
) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .commit_i      (commit_w),
    .commit_mode_i (commit_mode_w),
    .sync_lvl_i    (sync_lvl_w),
    .bit_cnt_i     (bit_cnt_w),
    .code_i        (code_o),
    .mode_i        (mode_o),
    .pd_i          (pd_o),
    .valid_i       (out_valid_o)
);

// File: tb/sdac_input_reg_tb.sv
// Bench: drives serial frames at the pins and checks outputs against values
// computed from the requirements. Wake-up window shortened to 12 clocks.
module sdac_input_reg_tb_top;

    localparam int WAKE = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_n = 1'b1;
    logic       sclk = 1'b1;
    logic       din = 1'b0;
    logic [7:0] code;
    logic [1:0] mode;
    logic       pd;
    logic [1:0] sel;
    logic       valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int wake_run = 0;
    int last_wake = -1;
    bit wake_armed = 1'b0;
    bit saw_invalid = 1'b0;

    always #2.5 clk = ~clk;

    sdac_input_reg #(.WAKE_CYCLES(WAKE)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sync_ni     (sync_n),
        .sclk_i      (sclk),
        .din_i       (din),
        .code_o      (code),
        .mode_o      (mode),
        .pd_o        (pd),
        .out_sel_o   (sel),
        .out_valid_o (valid)
    );

    // Bench-side measurement of the wake-up window and of valid drops.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!valid) saw_invalid = 1'b1;
            if (pd) begin
                wake_armed = 1'b1;
                wake_run   = 0;
            end else if (wake_armed) begin
                wake_run++;
                if (valid) begin
                    last_wake  = wake_run - 1;
                    wake_armed = 1'b0;
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] mk(input logic [7:0] c, input logic [1:0] m,
                                       input logic [5:0] junk);
        return {junk[5:4], m, c, junk[3:0]};
    endfunction

    // Send nfalls falling edges; bits past 16 alternate.
    task automatic send(input logic [15:0] w, input int nfalls);
        sync_n = 1'b0;
        clks(4);
        for (int i = 0; i < nfalls; i++) begin
            din = (i < 16) ? w[15-i] : i[0];
            clks(3);
            sclk = 1'b0;
            clks(3);
            sclk = 1'b1;
        end
        clks(3);
        sync_n = 1'b1;
        clks(8);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        clks(4);
        rst_n = 1'b1;
        clks(2);
        // R1 reset state
        chk("R1 code", int'(code), 0);
        chk("R1 mode", int'(mode), 0);
        chk("R1 pd", int'(pd), 0);
        chk("R1 sel", int'(sel), 0);
        chk("R1 valid", int'(valid), 1);

        // R2 sweep of all codes, R6 filler bits vary with the code
        for (int c = 0; c < 256; c++) begin
            send(mk(8'(c), 2'd0, 6'(c ^ 8'h2D)), 16);
            chk("R2 code sweep", int'(code), c);
        end

        // R6 filler all ones and all zeros
        send(mk(8'h81, 2'd0, 6'h3F), 16);
        chk("R6 filler ones", int'(code), 8'h81);
        chk("R6 filler ones mode", int'(mode), 0);
        send(mk(8'h7E, 2'd0, 6'h00), 16);
        chk("R6 filler zeros", int'(code), 8'h7E);

        // R3 each power-down mode, R5 code held, R8 valid and wake count
        for (int m = 1; m < 4; m++) begin
            send(mk(8'h6E, 2'd0, 6'h15), 16);
            chk("R9 base code", int'(code), 8'h6E);
            send(mk(8'h91, 2'(m), 6'h2A), 16);
            chk("R3 mode", int'(mode), m);
            chk("R3 sel", int'(sel), m);
            chk("R3 pd", int'(pd), 1);
            chk("R5 code held", int'(code), 8'h6E);
            chk("R8 valid low in pd", int'(valid), 0);
            last_wake = -1;
            send(mk(8'hB4, 2'd0, 6'h09), 16);
            clks(WAKE + 4);
            chk("R3 back to normal sel", int'(sel), 0);
            chk("R3 pd cleared", int'(pd), 0);
            chk("R2 code after wake", int'(code), 8'hB4);
            chk("R8 wake length", last_wake, WAKE);
            chk("R8 valid after wake", int'(valid), 1);
        end

        // R5/R8 power-down to another power-down
        send(mk(8'h44, 2'd0, 6'h00), 16);
        clks(WAKE + 4);
        send(mk(8'h10, 2'd1, 6'h00), 16);
        send(mk(8'h20, 2'd2, 6'h00), 16);
        chk("R3 pd to pd sel", int'(sel), 2);
        chk("R5 pd to pd code", int'(code), 8'h44);
        chk("R8 pd to pd valid", int'(valid), 0);
        send(mk(8'h33, 2'd0, 6'h00), 16);
        clks(WAKE + 4);

        // R4 abort after every length 1..15
        for (int n = 1; n < 16; n++) begin
            send(mk(8'hCC, 2'd3, 6'h3F), n);
            chk("R4 abort code", int'(code), 8'h33);
            chk("R4 abort mode", int'(mode), 0);
            chk("R4 abort valid", int'(valid), 1);
        end
        send(mk(8'h96, 2'd0, 6'h00), 16);
        chk("R4 frame after abort", int'(code), 8'h96);

        // R7 extra falling edges within one frame
        send(mk(8'h5C, 2'd0, 6'h00), 21);
        chk("R7 extra edges code", int'(code), 8'h5C);
        chk("R7 extra edges mode", int'(mode), 0);

        // R9 normal frame while normal keeps valid high
        saw_invalid = 1'b0;
        send(mk(8'h11, 2'd0, 6'h00), 16);
        clks(WAKE + 4);
        chk("R9 valid never dropped", int'(saw_invalid), 0);
        chk("R9 code", int'(code), 8'h11);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule